// File: doc/BRIEF.md
# Stereo I2S Master Audio Controller

This block is a two-channel I2S bus master with a small word-wide register interface. Software programs a bit-clock divider and a per-channel word length. It fills a transmit sample queue and drains a receive sample queue, one 32-bit word per access. It enables playback and capture independently. While either direction is enabled, the block divides its own clock down to a bit clock and drives a word-select line. It serialises transmit words onto the data output and assembles receive words from the data input.

A frame carries the left channel first (word-select low), then the right channel (word-select high). Word-select changes one bit period before each channel's most significant bit. Outgoing data changes on the falling edge of the bit clock, and incoming data is sampled on the rising edge. The bus and the audio logic share a single clock. Bus writes take effect on the strobe edge, and bus reads return data one cycle after the read strobe.

Top module: `i2s_audio_ctrl`

## Requirements
- R1: After reset the control word (offset 0x04) reads 0 and the clock word (offset 0x08) reads 0x001F0000. The status word (offset 0x10) reads 0x5, and the bit clock, word-select and data output are all low.
- R2: Writing offset 0x00 issues one-cycle commands. Bit 0 returns every register and both queues to the R1 state, bit 1 empties the transmit queue and bit 2 empties the receive queue. Offset 0x00 always reads 0, and each command clears itself.
- R3: Control bit 0 enables transmit and bit 1 enables receive, and the control word reads back as written. The bit clock runs while either bit is set and rests low while both are clear.
- R4: Clock-word bits [7:0] hold the divider d. Each bit-clock half period lasts d+1 clock cycles.
- R5: Clock-word bits [20:16] hold N-1, where N is the bits per channel, so a frame lasts 2N bit clocks. Word-select is low for left and high for right, and it changes on a bit-clock falling edge one bit before the channel's MSB. Data goes out MSB first, and each channel sends the top N bits of its word.
- R6: Transmit words are taken from the queue alternately for left and right. When the queue is empty at a channel start while transmit is enabled, that channel sends all zeros.
- R7: Receive data is sampled on the bit-clock rising edge. Each channel's N bits are stored MSB-aligned with the low bits zero, left before right.
- R8: Each queue holds 16 words. A write to offset 0x2C while the transmit queue is full is dropped. Status bit 0 is transmit-empty, bit 1 transmit-full, bit 2 receive-empty and bit 3 receive-full.
- R9: Reading offset 0x28 removes the oldest receive word and returns it. When the receive queue is empty the read returns 0.
- R10: Reading an offset other than 0x00, 0x04, 0x08, 0x10 or 0x28 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Single clock for the bus and the audio logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Single-cycle read strobe |
| addr_i | input | 6 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after rd_en_i |
| bclk_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word-select, low for left |
| sdo_o | output | 1 | Serial transmit data |
| sdi_i | input | 1 | Serial receive data |

## Verification
A wrong frame position or shift state shows up within one frame (2N bit clocks) as a decoded word that is rotated or shifted by one bit, or as a word reported on the wrong word-select level. The bench decodes the serial line without reference to the design, and it loops the data output back to the input. This lets a receive-side misalignment surface on the first word read back from the receive queue. A queue pointer or level fault shows up at the status word as soon as the seventeenth word is written, and in the order of the words read back after the queue fills. Divider faults change the measured half period on the next toggle of the bit clock.

// File: rtl/i2s_audio_pkg.sv
package i2s_audio_pkg;
  localparam int DATA_W = 32;
  localparam int WL_W   = 5;

  localparam logic [7:0] OFS_CMD    = 8'h00;
  localparam logic [7:0] OFS_CTRL   = 8'h04;
  localparam logic [7:0] OFS_CLK    = 8'h08;
  localparam logic [7:0] OFS_STATUS = 8'h10;
  localparam logic [7:0] OFS_RXQ    = 8'h28;
  localparam logic [7:0] OFS_TXQ    = 8'h2C;

  localparam logic [WL_W-1:0] WL_DEFAULT = 5'd31;

  // Place the last received bits at the top of the word, low bits zero.
  function automatic logic [DATA_W-1:0] msb_align(logic [DATA_W-1:0] v, logic [WL_W-1:0] wl);
    return v << (WL_W'(DATA_W - 1) - wl);
  endfunction

  // Bit periods per channel.
  function automatic logic [WL_W+1:0] chan_bits(logic [WL_W-1:0] wl);
    return (WL_W+2)'(wl) + (WL_W+2)'(1);
  endfunction
endpackage

// File: rtl/i2s_sample_fifo.sv
module i2s_sample_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (level == '0);
  assign full    = (level == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; level <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; level <= '0;
    end else begin
      if (do_push) wp <= wp + AW'(1);
      if (do_pop)  rp <= rp + AW'(1);
      level <= level + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end
endmodule

// File: rtl/i2s_bclk_gen.sv
module i2s_bclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             bclk,
  output logic             tick,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [DIV_W-1:0] cnt;

  assign tick     = run && (cnt == div);
  assign rise_evt = tick && !bclk;
  assign fall_evt = tick && bclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; bclk <= 1'b0;
    end else if (!run) begin
      cnt <= '0; bclk <= 1'b0;
    end else if (tick) begin
      cnt <= '0; bclk <= ~bclk;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/i2s_frame_engine.sv
module i2s_frame_engine
  import i2s_audio_pkg::*;
#(
  localparam int POS_W = WL_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic [WL_W-1:0]   wl,
  input  logic              fall_evt,
  input  logic              rise_evt,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              tx_avail,
  output logic              tx_pop,
  output logic              underrun,
  input  logic              sdi,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_word,
  output logic              ws,
  output logic              sdo
);
  logic [POS_W-1:0]  pos, half, frame, last, dtmp, dpos;
  logic [DATA_W-1:0] tx_sh, rx_sh, rx_next, sample;
  logic              load, fetch, raw_bit, raw_prev, started, left_seen;
  logic              rx_left_done, rx_right_done;

  assign half  = chan_bits(wl);
  assign frame = half << 1;
  assign last  = frame - POS_W'(1);
  assign load  = (pos == '0) || (pos == half);
  assign fetch = tx_en && tx_avail;
  assign sample   = fetch ? tx_word : '0;
  assign tx_pop   = fall_evt && load && fetch;
  assign underrun = fall_evt && load && tx_en && !tx_avail;
  assign raw_bit  = load ? sample[DATA_W-1] : tx_sh[DATA_W-1];

  // A rising edge carries the bit chosen two positions before the current count.
  assign dtmp = pos + frame - POS_W'(2);
  assign dpos = (dtmp >= frame) ? dtmp - frame : dtmp;

  assign rx_next       = {rx_sh[DATA_W-2:0], sdi};
  assign rx_word       = msb_align(rx_next, wl);
  assign rx_left_done  = rise_evt && started && rx_en && (dpos == half - POS_W'(1));
  assign rx_right_done = rise_evt && started && rx_en && (dpos == last) && left_seen;
  assign rx_push       = rx_left_done || rx_right_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0; ws <= 1'b0; sdo <= 1'b0; raw_prev <= 1'b0;
      tx_sh <= '0; rx_sh <= '0; started <= 1'b0; left_seen <= 1'b0;
    end else if (!run) begin
      pos <= '0; ws <= 1'b0; sdo <= 1'b0; raw_prev <= 1'b0;
      tx_sh <= '0; rx_sh <= '0; started <= 1'b0; left_seen <= 1'b0;
    end else begin
      if (fall_evt) begin
        ws       <= (pos >= half);
        sdo      <= raw_prev;
        raw_prev <= raw_bit;
        tx_sh    <= load ? (sample << 1) : (tx_sh << 1);
        pos      <= (pos == last) ? '0 : pos + POS_W'(1);
        started  <= 1'b1;
      end
      if (rise_evt && started) rx_sh <= rx_next;
      if (rx_left_done) left_seen <= 1'b1;
    end
  end
endmodule

// File: rtl/i2s_audio_ctrl.sv
module i2s_audio_ctrl
  import i2s_audio_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DEPTH       = 16,
  parameter int DIV_W       = 8,
  parameter int DEFAULT_DIV = 0,
  localparam int LVL_W      = $clog2(DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              bclk_o,
  output logic              ws_o,
  output logic              sdo_o,
  input  logic              sdi_i
);
  logic [1:0]        ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic [WL_W-1:0]   wl_q;
  logic [2:0]        cmd_q;
  logic              run, tick, rise_evt, fall_evt, tx_pop, underrun, rx_push;
  logic              tx_empty, tx_full, rx_empty, rx_full, tx_flush, rx_flush;
  logic              tx_wr, rx_rd;
  logic [DATA_W-1:0] tx_head, rx_head, rx_word;
  logic [LVL_W-1:0]  tx_level, rx_level;

  function automatic logic hit(logic [ADDR_W-1:0] a, logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign run      = |ctrl_q;
  assign tx_flush = cmd_q[0] | cmd_q[1];
  assign rx_flush = cmd_q[0] | cmd_q[2];
  assign tx_wr    = wr_en_i && hit(addr_i, OFS_TXQ);
  assign rx_rd    = rd_en_i && hit(addr_i, OFS_RXQ);

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; div_q <= DIV_W'(DEFAULT_DIV); wl_q <= WL_DEFAULT; cmd_q <= '0;
    end else begin
      cmd_q <= (wr_en_i && hit(addr_i, OFS_CMD)) ? wdata_i[2:0] : 3'b000;
      if (cmd_q[0]) begin
        ctrl_q <= '0; div_q <= DIV_W'(DEFAULT_DIV); wl_q <= WL_DEFAULT;
      end else if (wr_en_i) begin
        if (hit(addr_i, OFS_CTRL)) ctrl_q <= wdata_i[1:0];
        if (hit(addr_i, OFS_CLK)) begin
          div_q <= wdata_i[DIV_W-1:0];
          wl_q  <= wdata_i[16 +: WL_W];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) rdata_o <= '0;
    else if (rd_en_i) begin
      if (hit(addr_i, OFS_CTRL))        rdata_o <= {30'd0, ctrl_q};
      else if (hit(addr_i, OFS_CLK))    rdata_o <= {11'd0, wl_q, 16'(div_q)};
      else if (hit(addr_i, OFS_STATUS)) rdata_o <= {28'd0, rx_full, rx_empty, tx_full, tx_empty};
      else if (hit(addr_i, OFS_RXQ))    rdata_o <= rx_empty ? '0 : rx_head;
      else                              rdata_o <= '0;
    end
  end

  i2s_sample_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk_i), .rst_n(rst_n), .flush(tx_flush), .push(tx_wr), .wdata(wdata_i),
    .pop(tx_pop), .head(tx_head), .empty(tx_empty), .full(tx_full), .level(tx_level));

  i2s_sample_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk_i), .rst_n(rst_n), .flush(rx_flush), .push(rx_push), .wdata(rx_word),
    .pop(rx_rd), .head(rx_head), .empty(rx_empty), .full(rx_full), .level(rx_level));

  i2s_bclk_gen #(.DIV_W(DIV_W)) u_bclk (
    .clk(clk_i), .rst_n(rst_n), .run(run), .div(div_q), .bclk(bclk_o),
    .tick(tick), .rise_evt(rise_evt), .fall_evt(fall_evt));

  i2s_frame_engine u_eng (
    .clk(clk_i), .rst_n(rst_n), .run(run), .tx_en(ctrl_q[0]), .rx_en(ctrl_q[1]),
    .wl(wl_q), .fall_evt(fall_evt), .rise_evt(rise_evt), .tx_word(tx_head),
    .tx_avail(!tx_empty), .tx_pop(tx_pop), .underrun(underrun), .sdi(sdi_i),
    .rx_push(rx_push), .rx_word(rx_word), .ws(ws_o), .sdo(sdo_o));
endmodule

// File: rtl/i2s_audio_ctrl_chk.sv
module i2s_audio_ctrl_chk #(
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 16,
  parameter int LVL_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       rdata,
  input logic [2:0]        cmd,
  input logic              run,
  input logic              tick,
  input logic              bclk,
  input logic              ws,
  input logic              sdo,
  input logic              tx_pop,
  input logic              underrun,
  input logic              tx_empty,
  input logic              rx_empty,
  input logic [LVL_W-1:0]  tx_level,
  input logic [LVL_W-1:0]  rx_level
);
  AST_CMD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd && !(wr_en && addr == ADDR_W'(8'h00))) |=> (cmd == 3'b000)); // R2
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!bclk && !ws && !sdo)); // R3
  AST_BCLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(bclk)); // R4
  AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && ws != $past(ws)) |-> $fell(bclk)); // R5
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty); // R6
  AST_UNDERRUN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> tx_empty); // R6
  AST_TX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= LVL_W'(DEPTH)); // R8
  AST_RX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= LVL_W'(DEPTH)); // R8
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(8'h28) && rx_empty) |=> (rdata == 32'd0)); // R9
endmodule

bind i2s_audio_ctrl i2s_audio_ctrl_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk_i), .rst_n(rst_n), .wr_en(wr_en_i), .rd_en(rd_en_i), .addr(addr_i),
  .rdata(rdata_o), .cmd(cmd_q), .run(run), .tick(tick), .bclk(bclk_o), .ws(ws_o),
  .sdo(sdo_o), .tx_pop(tx_pop), .underrun(underrun), .tx_empty(tx_empty),
  .rx_empty(rx_empty), .tx_level(tx_level), .rx_level(rx_level));

// File: tb/i2s_audio_ctrl_tb.sv
`timescale 1ns/1ps
module i2s_audio_ctrl_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        bclk, ws;
  wire         sdo;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  i2s_audio_ctrl u_dut (
    .clk_i(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .bclk_o(bclk), .ws_o(ws), .sdo_o(sdo), .sdi_i(sdo));

  // Independent serial decoder: a word closes on the rise where word-select has changed.
  logic [31:0] dec_val [256];
  logic        dec_ch  [256];
  int          dec_n = 0, arm_req = 0, arm_seen = 0;
  logic [31:0] dec_mask = 32'hFFFF_FFFF, sh = '0;
  logic        prev_ws = 1'b0, bclk_prev = 1'b0;
  int          cyc = 0, last_tog = 0, last_half = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (arm_seen != arm_req) begin arm_seen = arm_req; prev_ws = 1'b0; end
    if (bclk != bclk_prev) begin last_half = cyc - last_tog; last_tog = cyc; end
    if (bclk && !bclk_prev) begin
      sh = {sh[30:0], sdo};
      if (ws != prev_ws) begin
        dec_val[dec_n % 256] = sh & dec_mask;
        dec_ch[dec_n % 256]  = prev_ws;
        dec_n = dec_n + 1;
      end
      prev_ws = ws;
    end
    bclk_prev = bclk;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(logic [5:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Enable with the given control value, wait for k decoded words, then stop.
  task automatic run_words(logic [1:0] c, int k, output int base);
    arm_req++; idle(1); base = dec_n;
    bus_wr(6'h04, {30'd0, c});
    for (int i = 0; i < 20000 && dec_n - base < k; i++) @(negedge clk);
    bus_wr(6'h04, 32'd0); idle(2);
  endtask

  task automatic t_reset_state;
    logic [31:0] v;
    check("R1 bclk idle", {31'd0, bclk}, 32'd0);
    check("R1 ws idle", {31'd0, ws}, 32'd0);
    check("R1 sdo idle", {31'd0, sdo}, 32'd0);
    bus_rd(6'h04, v); check("R1 ctrl", v, 32'd0);
    bus_rd(6'h08, v); check("R1 clock word", v, 32'h001F_0000);
    bus_rd(6'h10, v); check("R1 status", v, 32'h5);
    bus_rd(6'h00, v); check("R2 cmd reads zero", v, 32'd0);
    bus_rd(6'h0C, v); check("R10 unmapped offset", v, 32'd0);
    bus_rd(6'h2C, v); check("R10 tx port reads zero", v, 32'd0);
  endtask

  task automatic t_clock_div;
    logic [31:0] v;
    bus_wr(6'h08, 32'h001F_0003);
    bus_wr(6'h04, 32'h2); idle(40);
    check("R4 half period d=3", last_half, 32'd4);
    bus_rd(6'h04, v); check("R3 ctrl readback", v, 32'h2);
    bus_wr(6'h08, 32'h001F_0005); idle(50);
    check("R4 half period d=5", last_half, 32'd6);
    bus_wr(6'h04, 32'h0); idle(3);
    check("R3 bclk rests low", {31'd0, bclk}, 32'd0);
    idle(20);
    check("R3 bclk stays low", {31'd0, bclk}, 32'd0);
    bus_wr(6'h08, 32'h001F_0000);
  endtask

  task automatic t_stereo_loop;
    logic [31:0] v; int b;
    logic [31:0] w [4] = '{32'hA5A5_0001, 32'h8000_00FF, 32'h1234_5678, 32'hFEDC_BA98};
    bus_wr(6'h00, 32'h4);
    for (int i = 0; i < 4; i++) bus_wr(6'h2C, w[i]);
    run_words(2'b11, 4, b);
    for (int i = 0; i < 4; i++) begin
      check("R5 serial word MSB first", dec_val[(b + i) % 256], w[i]);
      check("R6 channel order left/right", {31'd0, dec_ch[(b + i) % 256]}, i % 2);
    end
    for (int i = 0; i < 4; i++) begin
      bus_rd(6'h28, v); check("R7 received word", v, w[i]);
    end
    bus_wr(6'h00, 32'h4); idle(2);
    bus_rd(6'h10, v); check("R2 rx flush empties", v & 32'h4, 32'h4);
    bus_rd(6'h28, v); check("R9 empty read returns 0", v, 32'd0);
  endtask

  task automatic t_word16;
    logic [31:0] v; int b;
    bus_wr(6'h08, 32'h000F_0001);
    dec_mask = 32'h0000_FFFF;
    bus_wr(6'h2C, 32'h1234_5678);
    bus_wr(6'h2C, 32'h9ABC_DEF0);
    run_words(2'b11, 2, b);
    check("R5 16-bit left", dec_val[b % 256], 32'h1234);
    check("R5 16-bit right", dec_val[(b + 1) % 256], 32'h9ABC);
    bus_rd(6'h28, v); check("R7 16-bit aligned left", v, 32'h1234_0000);
    bus_rd(6'h28, v); check("R7 16-bit aligned right", v, 32'h9ABC_0000);
    dec_mask = 32'hFFFF_FFFF;
    bus_wr(6'h08, 32'h001F_0000);
    bus_wr(6'h00, 32'h4);
  endtask

  task automatic t_underrun;
    logic [31:0] v; int b;
    run_words(2'b01, 2, b);
    check("R6 underrun left zero", dec_val[b % 256], 32'd0);
    check("R6 underrun right zero", dec_val[(b + 1) % 256], 32'd0);
    bus_rd(6'h10, v); check("R3 rx untouched while disabled", v & 32'h4, 32'h4);
  endtask

  task automatic t_fifo_limits;
    logic [31:0] v; int b;
    bus_wr(6'h00, 32'h6);
    for (int i = 1; i <= 17; i++) bus_wr(6'h2C, 32'h100 + i);
    bus_rd(6'h10, v); check("R8 tx full flag", v & 32'h3, 32'h2);
    run_words(2'b11, 18, b);
    for (int i = 0; i < 16; i++)
      check("R8 queued words in order", dec_val[(b + i) % 256], 32'h101 + i);
    check("R8 write when full dropped", dec_val[(b + 16) % 256], 32'd0);
    bus_rd(6'h10, v); check("R8 rx full flag", v & 32'hC, 32'h8);
    for (int i = 0; i < 16; i++) begin
      bus_rd(6'h28, v); check("R9 rx pop order", v, 32'h101 + i);
    end
    bus_rd(6'h28, v); check("R9 read past empty", v, 32'd0);
    bus_rd(6'h10, v); check("R8 rx empty flag", v & 32'hC, 32'h4);
  endtask

  task automatic t_tx_flush;
    logic [31:0] v;
    bus_wr(6'h2C, 32'h1); bus_wr(6'h2C, 32'h2);
    bus_rd(6'h10, v); check("R8 tx not empty", v & 32'h1, 32'h0);
    bus_wr(6'h00, 32'h2); idle(2);
    bus_rd(6'h10, v); check("R2 tx flush empties", v & 32'h1, 32'h1);
    bus_rd(6'h00, v); check("R2 cmd self-clears", v, 32'd0);
  endtask

  task automatic t_global;
    logic [31:0] v;
    bus_wr(6'h08, 32'h0007_0009);
    bus_wr(6'h2C, 32'h55);
    bus_wr(6'h04, 32'h3); idle(30);
    bus_wr(6'h00, 32'h1); idle(3);
    bus_rd(6'h04, v); check("R2 global clears ctrl", v, 32'd0);
    bus_rd(6'h08, v); check("R2 global restores clock word", v, 32'h001F_0000);
    bus_rd(6'h10, v); check("R2 global empties queues", v, 32'h5);
    check("R2 global stops bclk", {31'd0, bclk}, 32'd0);
  endtask

  initial begin
    idle(3); rst_n = 1'b1; idle(2);
    t_reset_state();
    t_clock_div();
    t_stereo_loop();
    t_word16();
    t_underrun();
    t_fifo_limits();
    t_tx_flush();
    t_global();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule